// File: doc/BRIEF.md
# UART Receive Buffer with Trigger Level and Character Timeout

This block buffers received characters between a serial deserialiser and the register read path of a 16550-style UART. Each receive event delivers either a data byte or a break indication. In buffered mode the block holds up to sixteen bytes in arrival order. It raises a threshold flag once the fill level reaches a programmable trigger count. It also raises a timeout flag when data has waited too long without any traffic. In unbuffered mode a single holding byte stands in for the queue.

The FIFO control write sets up the block: the enable bit, the two one-shot flush bits and the trigger code. The timeout is measured in bit periods, which a `bit_tick` strobe marks, against four character frames. The frame length comes from the line format word. The line status flags for data-ready, overrun and break are kept here. Interrupt prioritisation and the deserialiser itself live elsewhere.

Top module: `uart_rxbuf`

## Requirements
- R1: After reset the fill level is 0, data_ready, overrun, brk_flag, timeout_pend, trig_hit, fifo_on and tx_flush are 0, and fcr_held is 0x00 (unbuffered mode).
- R2: In unbuffered mode a received byte is held and sets data_ready. A read returns it and clears data_ready. A byte that arrives while data_ready is set (with no read in that cycle) replaces the held byte and sets overrun.
- R3: On a cfg_wr, bit 0 of cfg_data selects buffered mode, bit 1 flushes the receive queue and bit 2 pulses tx_flush for one cycle after the write. Bits 7:6 are the trigger code. Only bits 7, 6, 3 and 0 are kept in fcr_held. A write that changes bit 0 forces both flushes.
- R4: Trigger code 0, 1, 2 and 3 selects 1, 4, 8 and 14 bytes respectively. trig_hit is high in buffered mode exactly when the fill level is at least the selected count.
- R5: In buffered mode bytes are read back in arrival order from 16 entries. A byte arriving while the queue is full, with no read in the same cycle, is discarded. It sets overrun and leaves the stored bytes unchanged.
- R6: In buffered mode a read of an empty queue returns 0x00. A read that empties the queue clears data_ready and brk_flag.
- R7: A break event stores a 0x00 byte and sets brk_flag and data_ready.
- R8: An lsr_rd strobe clears brk_flag and overrun. A new overrun or break in the same cycle takes precedence.
- R9: In buffered mode with data stored, timeout_pend rises on the bit_tick that completes 4*F ticks with no receive and no read. F = 1 + (5 + line_fmt[1:0]) + line_fmt[3] + (line_fmt[2] ? 2 : 1).
- R10: A read clears timeout_pend, and the count restarts if data remains. Any receive restarts the count. A receive flush clears timeout_pend.
- R11: With the queue full, a read and a receive in the same cycle both take effect. The read returns the oldest byte, the new byte is stored last, the level stays 16 and overrun is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | FIFO control write strobe |
| cfg_data | input | 8 | FIFO control write value |
| line_fmt | input | 4 | Frame format: [1:0] data length code, [2] two stop bits, [3] parity on |
| bit_tick | input | 1 | One pulse per bit period |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | DW | Received byte |
| rx_break | input | 1 | Break received strobe |
| rd_req | input | 1 | Read of the receive data register |
| rd_data | output | DW | Data returned for the read in the same cycle |
| lsr_rd | input | 1 | Line status read strobe |
| data_ready | output | 1 | Data available |
| overrun | output | 1 | Overrun flag |
| brk_flag | output | 1 | Break flag |
| timeout_pend | output | 1 | Character timeout pending |
| trig_hit | output | 1 | Fill level at or above trigger |
| fill_level | output | LW | Stored byte count |
| fifo_on | output | 1 | Buffered mode active |
| fcr_held | output | 8 | Retained control bits |
| tx_flush | output | 1 | One-cycle flush request to the transmit queue |

## Verification
The critical collision is a read and a receive that land in the same cycle while all sixteen entries are occupied. The pop frees the slot the push needs, so the push must be accepted even though the queue looked full at the start of the cycle. The bench fills the queue, drives rd_req and rx_valid together in one cycle, and checks the byte returned in that cycle. It then checks that the level is still 16 and that overrun stayed low. Draining the queue must yield the remaining fifteen old bytes followed by the new one.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

  localparam int TO_W = 6;

  // Trigger code to byte count.
  function automatic logic [4:0] trig_bytes(input logic [1:0] code);
    case (code)
      2'd0:    trig_bytes = 5'd1;
      2'd1:    trig_bytes = 5'd4;
      2'd2:    trig_bytes = 5'd8;
      default: trig_bytes = 5'd14;
    endcase
  endfunction

  // Bits in one frame: start + data + optional parity + stop bits.
  function automatic logic [3:0] frame_bits(input logic [3:0] fmt);
    frame_bits = 4'd6 + {2'b00, fmt[1:0]} + {3'b000, fmt[3]}
               + (fmt[2] ? 4'd2 : 4'd1);
  endfunction

  // Four frames measured in bit ticks.
  function automatic logic [TO_W-1:0] timeout_ticks(input logic [3:0] fmt);
    timeout_ticks = {frame_bits(fmt), 2'b00};
  endfunction

endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          take, give;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    nxt = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
  assign take  = push && (!full || pop);
  assign give  = pop && !empty;
  assign dout  = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (take) wp <= nxt(wp);
      if (give) rp <= nxt(rp);
      case ({take, give})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take && !flush) mem[wp] <= din;
  end

  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (level == LW'(DEPTH)));

  // R5
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

endmodule

// File: rtl/rxbuf_timer.sv
module rxbuf_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          active,
  input  logic          restart,
  input  logic          clear,
  input  logic [TW-1:0] limit,
  output logic          pend
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (clear) pend <= 1'b0;
      if (restart || clear || !active) begin
        cnt <= '0;
      end else if (tick && !pend) begin
        if (cnt == limit - 1'b1) begin
          pend <= 1'b1;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R9
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> ($past(active) && $past(tick)));

  // R10
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !pend);

endmodule

// File: rtl/uart_rxbuf.sv
module uart_rxbuf
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_data,
  input  logic [3:0]    line_fmt,
  input  logic          bit_tick,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_break,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  input  logic          lsr_rd,
  output logic          data_ready,
  output logic          overrun,
  output logic          brk_flag,
  output logic          timeout_pend,
  output logic          trig_hit,
  output logic [LW-1:0] fill_level,
  output logic          fifo_on,
  output logic [7:0]    fcr_held,
  output logic          tx_flush
);

  logic [7:0]    fcr_q;
  logic [DW-1:0] hold_q;
  logic          hold_v, ovr_q, brk_q, txf_q;

  // Named internal events.
  logic          evt_rx, cfg_toggle, rx_clr, tx_clr;
  logic          f_push, f_pop, f_drop, f_left, f_emptied;
  logic          nf_rx, nf_rd, nf_ovr;
  logic [DW-1:0] evt_byte, q_dout;
  logic          q_full, q_empty;

  assign fifo_on    = fcr_q[0];
  assign evt_rx     = rx_valid || rx_break;
  assign evt_byte   = rx_break ? '0 : rx_byte;
  assign cfg_toggle = cfg_wr && (cfg_data[0] != fcr_q[0]);
  assign rx_clr     = cfg_wr && (cfg_data[1] || cfg_toggle);
  assign tx_clr     = cfg_wr && (cfg_data[2] || cfg_toggle);

  assign f_push    = fifo_on && evt_rx && !rx_clr;
  assign f_pop     = fifo_on && rd_req && !rx_clr;
  assign f_drop    = f_push && q_full && !f_pop;
  assign f_left    = f_pop && (fill_level > LW'(1));
  assign f_emptied = f_pop && (fill_level <= LW'(1)) && !f_push;

  assign nf_rx  = !fifo_on && evt_rx && !rx_clr;
  assign nf_rd  = !fifo_on && rd_req && !rx_clr;
  assign nf_ovr = nf_rx && hold_v && !nf_rd;

  rxbuf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (rx_clr),
    .push  (f_push),
    .pop   (f_pop),
    .din   (evt_byte),
    .dout  (q_dout),
    .level (fill_level),
    .full  (q_full),
    .empty (q_empty)
  );

  rxbuf_timer #(.TW(TO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (bit_tick),
    .active  (fifo_on && !q_empty),
    .restart (f_push || f_left),
    .clear   (f_pop || rx_clr),
    .limit   (timeout_ticks(line_fmt)),
    .pend    (timeout_pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcr_q  <= 8'h00;
      hold_q <= '0;
      hold_v <= 1'b0;
      ovr_q  <= 1'b0;
      brk_q  <= 1'b0;
      txf_q  <= 1'b0;
    end else begin
      txf_q <= tx_clr;
      if (cfg_wr) fcr_q <= cfg_data & 8'hC9;

      if (rx_clr) hold_v <= 1'b0;
      else if (nf_rx) begin
        hold_q <= evt_byte;
        hold_v <= 1'b1;
      end else if (nf_rd) hold_v <= 1'b0;

      if (f_drop || nf_ovr) ovr_q <= 1'b0 | 1'b1;
      else if (lsr_rd)      ovr_q <= 1'b0;

      if (rx_break && !rx_clr)                  brk_q <= 1'b1;
      else if (lsr_rd || f_emptied || nf_rd)    brk_q <= 1'b0;
    end
  end

  assign data_ready = fifo_on ? !q_empty : hold_v;
  assign rd_data    = fifo_on ? (q_empty ? '0 : q_dout) : hold_q;
  assign overrun    = ovr_q;
  assign brk_flag   = brk_q;
  assign fcr_held   = fcr_q;
  assign tx_flush   = txf_q;
  assign trig_hit   = fifo_on && (fill_level >= LW'(trig_bytes(fcr_q[7:6])));

  // R3
  toggle_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (cfg_data[0] != fifo_on)) |=> (fill_level == '0 && tx_flush));

  // R7
  break_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_break && !cfg_wr) |=> (brk_flag && data_ready));

  // R6
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && fifo_on && fill_level == '0) |-> (rd_data == '0));

  // R8
  lsr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rx_valid && !rx_break) |=> (!overrun && !brk_flag));

endmodule

// File: tb/uart_rxbuf_tb.sv
`timescale 1ns/100ps
module uart_rxbuf_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic [3:0] line_fmt = 4'b0011;
  logic       bit_tick = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_break = 1'b0;
  logic       rd_req = 1'b0;
  logic       lsr_rd = 1'b0;
  logic [7:0] rd_data;
  logic       data_ready, overrun, brk_flag, timeout_pend, trig_hit, fifo_on, tx_flush;
  logic [4:0] fill_level;
  logic [7:0] fcr_held;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  uart_rxbuf u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .line_fmt(line_fmt), .bit_tick(bit_tick), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_break(rx_break), .rd_req(rd_req),
    .rd_data(rd_data), .lsr_rd(lsr_rd), .data_ready(data_ready),
    .overrun(overrun), .brk_flag(brk_flag), .timeout_pend(timeout_pend),
    .trig_hit(trig_hit), .fill_level(fill_level), .fifo_on(fifo_on),
    .fcr_held(fcr_held), .tx_flush(tx_flush)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic brk();
    rx_break = 1'b1;
    @(negedge clk);
    rx_break = 1'b0;
  endtask

  task automatic rd(output logic [7:0] b);
    rd_req = 1'b1;
    #0.5 b = rd_data;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic cfg(input logic [7:0] v);
    cfg_wr = 1'b1; cfg_data = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic lsr();
    lsr_rd = 1'b1;
    @(negedge clk);
    lsr_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  endtask

  // Four frames in bit periods, written independently of the design.
  function automatic int limit_of(input logic [3:0] f);
    int bits;
    bits = 1 + 5 + int'(f & 4'd3) + (f[3] ? 1 : 0) + (f[2] ? 2 : 1);
    return bits * 4;
  endfunction

  task automatic t_reset();
    chk("R1 level", fill_level, 0);
    chk("R1 flags", {data_ready, overrun, brk_flag, timeout_pend, trig_hit, fifo_on, tx_flush}, 0);
    chk("R1 fcr_held", fcr_held, 8'h00);
  endtask

  task automatic t_unbuffered();
    logic [7:0] b;
    push(8'h11);
    chk("R2 data_ready set", data_ready, 1);
    rd(b);
    chk("R2 read byte", b, 8'h11);
    chk("R2 data_ready clear", data_ready, 0);
    push(8'h22);
    push(8'h33);
    chk("R2 overrun", overrun, 1);
    rd(b);
    chk("R2 replaced byte", b, 8'h33);
    lsr();
    chk("R8 overrun cleared", overrun, 0);
  endtask

  task automatic t_config();
    cfg(8'h01);
    chk("R3 tx_flush on toggle", tx_flush, 1);
    chk("R3 fifo_on", fifo_on, 1);
    chk("R3 fcr_held 01", fcr_held, 8'h01);
    cfg(8'hFF);
    chk("R3 retained bits", fcr_held, 8'hC9);
    chk("R3 tx flush bit", tx_flush, 1);
    cfg(8'h01);
    chk("R3 no tx flush", tx_flush, 0);
  endtask

  task automatic t_trigger();
    int tl[4] = '{1, 4, 8, 14};
    for (int c = 0; c < 4; c++) begin
      cfg({c[1:0], 6'b000011});
      for (int i = 0; i < tl[c] - 1; i++) push(8'(i));
      chk($sformatf("R4 below trigger code %0d", c), trig_hit, 0);
      push(8'hAA);
      chk($sformatf("R4 at trigger code %0d", c), trig_hit, 1);
    end
    cfg(8'h03);
  endtask

  task automatic t_order_overrun();
    logic [7:0] b;
    for (int i = 0; i < 16; i++) push(8'h80 + 8'(i));
    chk("R5 full level", fill_level, 16);
    chk("R5 no overrun yet", overrun, 0);
    push(8'hEE);
    chk("R5 overrun on full", overrun, 1);
    chk("R5 level kept", fill_level, 16);
    for (int i = 0; i < 16; i++) begin
      rd(b);
      chk("R5 order", b, 8'h80 + 8'(i));
    end
    chk("R6 data_ready clear on empty", data_ready, 0);
    rd(b);
    chk("R6 empty read zero", b, 8'h00);
    lsr();
  endtask

  task automatic t_break();
    logic [7:0] b;
    push(8'h5A);
    brk();
    chk("R7 break flag", brk_flag, 1);
    chk("R7 level two", fill_level, 2);
    rd(b);
    chk("R7 first byte", b, 8'h5A);
    chk("R6 break kept while data", brk_flag, 1);
    rd(b);
    chk("R7 break byte zero", b, 8'h00);
    chk("R6 break cleared on empty", brk_flag, 0);
    brk();
    chk("R7 data_ready on break", data_ready, 1);
    lsr();
    chk("R8 break cleared by status read", brk_flag, 0);
    cfg(8'h03);
  endtask

  task automatic t_timeout();
    logic [7:0] b;
    int lim;
    line_fmt = 4'b0011;
    lim = limit_of(line_fmt);
    push(8'h01);
    push(8'h02);
    ticks(lim - 1);
    chk("R9 not yet 8N1", timeout_pend, 0);
    ticks(1);
    chk("R9 pend 8N1", timeout_pend, 1);
    rd(b);
    chk("R10 read clears pend", timeout_pend, 0);
    ticks(lim - 1);
    chk("R10 restart after read", timeout_pend, 0);
    ticks(1);
    chk("R10 pend after restart", timeout_pend, 1);
    cfg(8'h03);
    chk("R10 flush clears pend", timeout_pend, 0);
    push(8'h03);
    ticks(20);
    push(8'h04);
    ticks(lim - 1);
    chk("R10 receive restarts", timeout_pend, 0);
    ticks(1);
    chk("R10 pend after receive restart", timeout_pend, 1);
    cfg(8'h03);
    line_fmt = 4'b1100;
    lim = limit_of(line_fmt);
    push(8'h05);
    ticks(lim - 1);
    chk("R9 not yet 5E2", timeout_pend, 0);
    ticks(1);
    chk("R9 pend 5E2", timeout_pend, 1);
    cfg(8'h03);
    line_fmt = 4'b0011;
  endtask

  task automatic t_same_cycle();
    logic [7:0] b;
    lsr();
    for (int i = 0; i < 16; i++) push(8'h40 + 8'(i));
    rx_valid = 1'b1; rx_byte = 8'hEE; rd_req = 1'b1;
    #0.5 b = rd_data;
    @(negedge clk);
    rx_valid = 1'b0; rd_req = 1'b0;
    chk("R11 oldest returned", b, 8'h40);
    chk("R11 level stays full", fill_level, 16);
    chk("R11 no overrun", overrun, 0);
    for (int i = 1; i < 16; i++) begin
      rd(b);
      chk("R11 drain order", b, 8'h40 + 8'(i));
    end
    rd(b);
    chk("R11 new byte last", b, 8'hEE);
  endtask

  task automatic t_toggle_off();
    push(8'h77);
    push(8'h78);
    cfg(8'h00);
    chk("R3 toggle flushes queue", fill_level, 0);
    chk("R3 toggle tx_flush", tx_flush, 1);
    chk("R3 mode off", fifo_on, 0);
    chk("R3 data_ready off", data_ready, 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unbuffered();
    t_config();
    t_trigger();
    t_order_overrun();
    t_break();
    t_timeout();
    t_same_cycle();
    t_toggle_off();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule